// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects up to 64 interrupt request lines and decides which one, if any, the processor should service next. Software programs it through a word-addressed write port and a separate read port. Each source has an enable, a pending flag, an active flag and a 4-bit priority. Smaller priority values are more urgent. Enables and pending flags are changed through separate set and clear locations, where a 1 bit acts and a 0 bit does nothing.

On the processor side the block drives a request-valid flag and the number of the chosen source. It takes an entry acknowledge when a handler starts and an exit strobe when the innermost handler returns. A stack of entered handlers records nesting. Its top gives the running priority, and a new request is forwarded only if it is strictly more urgent than that priority. The processor model also supplies a global mask bit and a base-priority threshold, and both can block forwarding.

The nesting tracker is a three-state machine. IDLE means no handler is running. SERVE means one or more handlers are running and the stack has room. FULL means every stack slot is used. The transitions are ENTER (IDLE to SERVE on an acknowledge), PREEMPT (SERVE to SERVE, or SERVE to FULL, on an acknowledge), RETURN (SERVE to SERVE, or FULL to SERVE, on an exit) and LAST_EXIT (SERVE to IDLE when the final handler exits). An exit strobe in IDLE is ignored. An acknowledge that arrives in the same cycle as an exit, or while the request-valid flag is low, is also ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word 0 (sources 0-31) and word 1 (sources 32-63) set enables, and words 2 and 3 clear them, for source n at bit n mod 32. Writing 0 to a bit changes nothing. Reads of words 0 to 3 return the enable bits of the addressed half.
- R2: Words 4 and 5 set pending flags, and words 6 and 7 clear them, with the same bit layout and the same write-1-acts rule. Set-pending makes a source pending even when its line is low. Reads of words 4 to 7 return the pending bits.
- R3: An accepted entry acknowledge clears the pending flag of the presented source and sets its active flag. Active flags are read from words 8 and 9.
- R4: If a source's line is still high when its handler exits, its pending flag is set again on the clock edge that follows the exit edge.
- R5: A rising edge on a source's line while that source is active sets its pending flag. An active source is never presented.
- R6: The priority of source n is kept in word 16 + n/4, bits [8*(n mod 4)+7 : 8*(n mod 4)+4]. The low four bits of each byte read back as 0. A lone pending, enabled source is presented with its own number.
- R7: A pending, enabled request is presented only if its priority value is strictly below the running priority. A request of equal or lower urgency waits.
- R8: While the global mask input is 1, the request-valid flag is 0.
- R9: A non-zero threshold presents only requests whose priority value is below the threshold. A threshold of 0 blocks nothing.
- R10: Among eligible requests the lowest priority value wins, and on equal values the lowest source number wins.
- R11: A line event that sets a pending flag wins over a clear-pending write in the same cycle.
- R12: The nesting stack holds 16 entries. An exit returns to the priority of the previously entered handler. With the stack empty, requests of every level are admitted, and an exit strobe is ignored.
- R13: A pending source whose enable is 0 is not presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_SRC | Request lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 5 | Read word address |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| cpu_mask | input | 1 | Global mask, 1 blocks all forwarding |
| cpu_basepri | input | PRIO_W | Base-priority threshold, 0 disables it |
| irq_valid | output | 1 | A request is offered to the processor |
| irq_num | output | ID_W | Number of the offered source |
| irq_enter | input | 1 | Handler-entry acknowledge for the offered source |
| irq_leave | input | 1 | Innermost handler exit strobe |

## Verification
Register writes, entry acknowledges and exit strobes take effect at the clock edge that samples them. The read data and the request outputs are combinational, so their effect can be seen half a cycle later. For that reason the bench drives at the falling edge and samples at the next falling edge. Mask and threshold changes reach irq_valid without a clock, so they are checked one time step after the input changes. The level re-arm after an exit needs the active flag to drop first, so it is checked one cycle later than the other results.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // Word addresses of the register port; bit 0 selects the upper source half
    localparam logic [2:0] GRP_EN_SET  = 3'd0;
    localparam logic [2:0] GRP_EN_CLR  = 3'd1;
    localparam logic [2:0] GRP_PD_SET  = 3'd2;
    localparam logic [2:0] GRP_PD_CLR  = 3'd3;
    localparam logic [2:0] GRP_ACTIVE  = 3'd4;

    // Nesting tracker states
    typedef enum logic [1:0] {
        NS_IDLE  = 2'd0,
        NS_SERVE = 2'd1,
        NS_FULL  = 2'd2
    } nest_state_t;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line,
    input  logic [NUM_SRC-1:0] en_set,
    input  logic [NUM_SRC-1:0] en_clr,
    input  logic [NUM_SRC-1:0] pd_set,
    input  logic [NUM_SRC-1:0] pd_clr,
    input  logic               ack_fire,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               pop,
    input  logic [ID_W-1:0]    pop_id,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] act
);

    logic [NUM_SRC-1:0] line_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic ack_i;
        logic pop_i;
        logic hw_set;

        assign ack_i  = ack_fire && (ack_id == ID_W'(i));
        assign pop_i  = pop && (pop_id == ID_W'(i));
        // level arms an idle source; a rising edge re-arms an active one
        assign hw_set = line[i] && ((!act[i] && !ack_i) || !line_q[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[i]     <= 1'b0;
                pend[i]   <= 1'b0;
                act[i]    <= 1'b0;
                line_q[i] <= 1'b0;
            end else begin
                line_q[i] <= line[i];
                if (en_set[i])
                    en[i] <= 1'b1;
                else if (en_clr[i])
                    en[i] <= 1'b0;
                if (hw_set || pd_set[i])
                    pend[i] <= 1'b1;
                else if (pd_clr[i] || ack_i)
                    pend[i] <= 1'b0;
                if (ack_i)
                    act[i] <= 1'b1;
                else if (pop_i)
                    act[i] <= 1'b0;
            end
        end

        // R3: entry without a concurrent re-arm leaves the source active, not pending
        assert_ack_clears_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !pd_set[i] && !(line[i] && !line_q[i])) |=> (act[i] && !pend[i]));

        // R4: line still high one cycle after exit re-arms the source
        assert_exit_rearm_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            (pop_i ##1 line[i]) |=> pend[i]);

        // R5: edge during service re-arms
        assert_pulse_rearm_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (act[i] && line[i] && !line_q[i]) |=> pend[i]);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         en,
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         act,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    input  logic [PRIO_W:0]            run_prio,
    input  logic                       gmask,
    input  logic [PRIO_W-1:0]          thresh,
    output logic                       req_valid,
    output logic [ID_W-1:0]            req_id,
    output logic [PRIO_W-1:0]          req_prio
);

    logic [NUM_SRC-1:0] cand;
    logic               found;
    logic               thresh_ok;

    assign cand = en & pend & ~act;

    // descending scan with <= lets the lowest number win a tie
    always_comb begin
        found    = 1'b0;
        req_id   = '0;
        req_prio = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] <= req_prio))) begin
                found    = 1'b1;
                req_id   = ID_W'(i);
                req_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assign thresh_ok = (thresh == '0) || (req_prio < thresh);
    assign req_valid = found && !gmask && thresh_ok && ({1'b0, req_prio} < run_prio);

    // R9: nothing at or beyond a non-zero threshold is offered
    assert_thresh_block_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && thresh != '0) |-> (prio_flat[req_id*PRIO_W +: PRIO_W] < thresh));

    // R13: only enabled, pending, idle sources are offered
    assert_offer_enabled_R13 : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (en[req_id] && pend[req_id] && !act[req_id]));

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import prio_irq_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              exit_req,
    output logic              pop,
    output logic [ID_W-1:0]   pop_id,
    output logic [PRIO_W:0]   run_prio
);

    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1 << PRIO_W);

    nest_state_t      st, st_nx;
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  top_ix;
    logic             push_ok;
    logic [ID_W-1:0]  id_stk [DEPTH];
    logic [PRIO_W-1:0] pr_stk [DEPTH];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= NS_IDLE;
        else        st <= st_nx;
    end

    // transitions: ENTER, PREEMPT, RETURN, LAST_EXIT
    always_comb begin
        st_nx = st;
        unique case (st)
            NS_IDLE: begin
                if (push && !exit_req)
                    st_nx = (DEPTH == 1) ? NS_FULL : NS_SERVE;
            end
            NS_SERVE: begin
                if (exit_req && sp == SP_W'(1))
                    st_nx = NS_IDLE;
                else if (push && !exit_req && sp == SP_W'(DEPTH - 1))
                    st_nx = NS_FULL;
            end
            NS_FULL: begin
                if (exit_req)
                    st_nx = (DEPTH == 1) ? NS_IDLE : NS_SERVE;
            end
            default: st_nx = NS_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        pop     = 1'b0;
        push_ok = 1'b0;
        unique case (st)
            NS_IDLE:  push_ok = push && !exit_req;
            NS_SERVE: begin
                pop     = exit_req;
                push_ok = push && !exit_req;
            end
            NS_FULL:  pop = exit_req;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (push_ok)
            sp <= sp + 1'b1;
        else if (pop)
            sp <= sp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            id_stk[sp[$clog2(DEPTH > 1 ? DEPTH : 2)-1:0]] <= push_id;
            pr_stk[sp[$clog2(DEPTH > 1 ? DEPTH : 2)-1:0]] <= push_prio;
        end
    end

    assign top_ix   = sp - 1'b1;
    assign pop_id   = id_stk[top_ix[$clog2(DEPTH > 1 ? DEPTH : 2)-1:0]];
    assign run_prio = (sp == '0) ? IDLE_PRIO
                                 : {1'b0, pr_stk[top_ix[$clog2(DEPTH > 1 ? DEPTH : 2)-1:0]]};

    // R12: arbitration must never offer a request into a full stack
    assert_no_push_full_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st != NS_FULL));

    // R12: IDLE state and an empty stack agree
    assert_idle_empty_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (st == NS_IDLE) == (sp == '0));

    // R7: each entry raises urgency strictly
    assert_preempt_strict_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (run_prio < $past(run_prio)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_line,
    input  logic               reg_wr,
    input  logic [4:0]         reg_waddr,
    input  logic [31:0]        reg_wdata,
    input  logic [4:0]         reg_raddr,
    output logic [31:0]        reg_rdata,
    input  logic               cpu_mask,
    input  logic [PRIO_W-1:0]  cpu_basepri,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_num,
    input  logic               irq_enter,
    input  logic               irq_leave
);

    localparam int DEPTH = 1 << PRIO_W;

    logic [NUM_SRC-1:0]        en, pend, act;
    logic [NUM_SRC-1:0]        en_set, en_clr, pd_set, pd_clr;
    logic [63:0]               wide;
    logic                      wsel;
    logic [PRIO_W-1:0]         prio [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]         sel_prio;
    logic [PRIO_W:0]           run_prio;
    logic                      ack_fire;
    logic                      pop;
    logic [ID_W-1:0]           pop_id;
    logic [63:0]               en_pad, pd_pad, act_pad;

    // ---------------- write decode ----------------
    assign wsel = reg_wr && !reg_waddr[4];
    assign wide = reg_waddr[0] ? {reg_wdata, 32'h0} : {32'h0, reg_wdata};

    always_comb begin
        en_set = '0;
        en_clr = '0;
        pd_set = '0;
        pd_clr = '0;
        if (wsel) begin
            unique case (reg_waddr[3:1])
                GRP_EN_SET: en_set = wide[NUM_SRC-1:0];
                GRP_EN_CLR: en_clr = wide[NUM_SRC-1:0];
                GRP_PD_SET: pd_set = wide[NUM_SRC-1:0];
                GRP_PD_CLR: pd_clr = wide[NUM_SRC-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio[i] <= '0;
            else if (reg_wr && reg_waddr[4] && reg_waddr[3:0] == 4'(i / 4))
                prio[i] <= reg_wdata[8*(i%4)+7 -: PRIO_W];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio[i];
    end

    // ---------------- read mux ----------------
    always_comb begin
        en_pad  = '0;
        pd_pad  = '0;
        act_pad = '0;
        en_pad[NUM_SRC-1:0]  = en;
        pd_pad[NUM_SRC-1:0]  = pend;
        act_pad[NUM_SRC-1:0] = act;
        reg_rdata = '0;
        if (reg_raddr[4]) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (reg_raddr[3:0] == 4'(i / 4))
                    reg_rdata[8*(i%4)+7 -: PRIO_W] = prio[i];
            end
        end else begin
            unique case (reg_raddr[3:1])
                GRP_EN_SET, GRP_EN_CLR:
                    reg_rdata = reg_raddr[0] ? en_pad[63:32] : en_pad[31:0];
                GRP_PD_SET, GRP_PD_CLR:
                    reg_rdata = reg_raddr[0] ? pd_pad[63:32] : pd_pad[31:0];
                GRP_ACTIVE:
                    reg_rdata = reg_raddr[0] ? act_pad[63:32] : act_pad[31:0];
                default: reg_rdata = '0;
            endcase
        end
    end

    // ---------------- handshake ----------------
    assign ack_fire = irq_enter && irq_valid && !irq_leave;

    irq_src_bank #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (irq_line),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pd_set   (pd_set),
        .pd_clr   (pd_clr),
        .ack_fire (ack_fire),
        .ack_id   (irq_num),
        .pop      (pop),
        .pop_id   (pop_id),
        .en       (en),
        .pend     (pend),
        .act      (act)
    );

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pend      (pend),
        .act       (act),
        .prio_flat (prio_flat),
        .run_prio  (run_prio),
        .gmask     (cpu_mask),
        .thresh    (cpu_basepri),
        .req_valid (irq_valid),
        .req_id    (irq_num),
        .req_prio  (sel_prio)
    );

    irq_nest_stack #(
        .ID_W   (ID_W),
        .PRIO_W (PRIO_W),
        .DEPTH  (DEPTH)
    ) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_fire),
        .push_id   (irq_num),
        .push_prio (sel_prio),
        .exit_req  (irq_leave),
        .pop       (pop),
        .pop_id    (pop_id),
        .run_prio  (run_prio)
    );

    // R8: the global mask silences the request output
    assert_mask_silences_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mask |-> !irq_valid);

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int PW = 4;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_line = '0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_waddr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [4:0]    reg_raddr = '0;
    logic [31:0]   reg_rdata;
    logic          cpu_mask = 1'b0;
    logic [PW-1:0] cpu_basepri = '0;
    logic          irq_valid;
    logic [IW-1:0] irq_num;
    logic          irq_enter = 1'b0;
    logic          irq_leave = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .cpu_mask(cpu_mask), .cpu_basepri(cpu_basepri),
        .irq_valid(irq_valid), .irq_num(irq_num),
        .irq_enter(irq_enter), .irq_leave(irq_leave)
    );

    function automatic int pf(int n);
        return (n * 7 + 3) % 16;
    endfunction

    task automatic check(string req, longint actual, longint expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pend_src(int n);
        wr(5'(4 + n / 32), 32'(1) << (n % 32));
    endtask

    task automatic clear_all_pend();
        wr(5'd6, '1);
        wr(5'd7, '1);
    endtask

    task automatic set_prio(int n, int p);
        logic [31:0] v;
        rd(5'(16 + n / 4), v);
        v[8*(n%4) +: 8] = 8'(p << 4);
        wr(5'(16 + n / 4), v);
    endtask

    task automatic enter();
        irq_enter = 1'b1; tick(); irq_enter = 1'b0;
    endtask

    task automatic leave();
        irq_leave = 1'b1; tick(); irq_leave = 1'b0;
    endtask

    task automatic vcheck(string req, bit exp_v, int exp_id);
        check(req, irq_valid, exp_v);
        if (exp_v) check(req, irq_num, exp_id);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_w;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        check("reset valid", irq_valid, 0);
        rd(5'd0, v); check("reset R1 enables", v, 0);
        rd(5'd4, v); check("reset R2 pending", v, 0);

        // R1: enable set/clear, write-0 no effect
        wr(5'd0, 32'h5); rd(5'd0, v); check("R1 set", v, 32'h5);
        wr(5'd0, 32'h0); rd(5'd0, v); check("R1 set zero", v, 32'h5);
        wr(5'd2, 32'h1); rd(5'd2, v); check("R1 clear", v, 32'h4);
        wr(5'd2, 32'h0); rd(5'd0, v); check("R1 clear zero", v, 32'h4);
        wr(5'd1, 32'h8000_0000); rd(5'd1, v); check("R1 upper set", v, 32'h8000_0000);
        wr(5'd3, 32'h8000_0000); rd(5'd3, v); check("R1 upper clear", v, 0);
        wr(5'd2, '1);

        // R2: pending set/clear with line low
        wr(5'd4, 32'h80); rd(5'd4, v); check("R2 set", v, 32'h80);
        wr(5'd4, 32'h0);  rd(5'd6, v); check("R2 set zero", v, 32'h80);
        wr(5'd6, 32'h0);  rd(5'd4, v); check("R2 clear zero", v, 32'h80);
        // R13: disabled pending source not offered
        check("R13 disabled", irq_valid, 0);
        wr(5'd0, 32'h80); vcheck("R13 enabled", 1, 7);
        wr(5'd6, 32'h80); rd(5'd4, v); check("R2 clear", v, 0);
        wr(5'd2, '1);

        // R6: priority layout, low nibble ignored
        for (int r = 0; r < 16; r++) begin
            exp_w = '0;
            for (int k = 0; k < 4; k++) exp_w[8*k +: 8] = 8'((pf(4*r+k) << 4) | 15);
            wr(5'(16 + r), exp_w);
        end
        for (int r = 0; r < 16; r++) begin
            exp_w = '0;
            for (int k = 0; k < 4; k++) exp_w[8*k +: 8] = 8'(pf(4*r+k) << 4);
            rd(5'(16 + r), v);
            check("R6 prio readback", v, exp_w);
        end

        wr(5'd0, '1); wr(5'd1, '1);
        for (int n = 0; n < N; n++) begin
            pend_src(n);
            vcheck("R6 lone source", 1, n);
            clear_all_pend();
        end

        // R10: pairwise arbitration
        for (int a = 0; a < N; a += 5) begin
            for (int b = a + 1; b < N; b += 13) begin
                int w;
                w = (pf(b) < pf(a)) ? b : a;
                pend_src(a); pend_src(b);
                vcheck("R10 pair", 1, w);
                clear_all_pend();
            end
        end
        // R10: equal-priority tie
        set_prio(3, 9); set_prio(10, 9);
        pend_src(10); pend_src(3);
        vcheck("R10 tie", 1, 3);
        clear_all_pend();

        // R8: global mask
        pend_src(5);
        cpu_mask = 1'b1; tick();
        check("R8 masked", irq_valid, 0);
        cpu_mask = 1'b0; #1;
        vcheck("R8 unmasked", 1, 5);

        // R9: threshold sweep, source 5 priority pf(5)=6
        for (int t = 0; t < 16; t++) begin
            cpu_basepri = 4'(t); #1;
            check("R9 threshold", irq_valid, (t == 0 || pf(5) < t) ? 1 : 0);
        end
        cpu_basepri = '0;
        @(negedge clk);
        clear_all_pend();

        // nesting: all priorities 15, then A=10:8, B=20:8, C=30:3, D=40:0
        for (int r = 0; r < 16; r++) wr(5'(16 + r), 32'hF0F0_F0F0);
        set_prio(10, 8); set_prio(20, 8); set_prio(30, 3); set_prio(40, 0);
        pend_src(10);
        vcheck("R7 first", 1, 10);
        enter();
        rd(5'd4, v); check("R3 pending cleared", v[10], 0);
        rd(5'd8, v); check("R3 active set", v[10], 1);
        pend_src(20);
        check("R7 equal waits", irq_valid, 0);
        pend_src(30);
        vcheck("R7 preempt", 1, 30);
        enter();
        pend_src(40);
        vcheck("R7 deeper preempt", 1, 40);
        enter();
        leave();
        rd(5'd9, v); check("R12 pop inner", v[8], 0);
        check("R12 back to prio 3", irq_valid, 0);
        leave();
        check("R12 back to prio 8", irq_valid, 0);
        leave();
        vcheck("R12 stack empty", 1, 20);
        enter(); leave();
        leave();
        check("R12 empty exit", irq_valid, 0);
        pend_src(50);
        vcheck("R12 lowest level admitted", 1, 50);
        clear_all_pend();

        // R4: line held high through handler
        irq_line[12] = 1'b1; tick();
        vcheck("R4 level", 1, 12);
        enter();
        rd(5'd4, v); check("R3 cleared under level", v[12], 0);
        leave(); tick();
        rd(5'd4, v); check("R4 rearm", v[12], 1);
        irq_line[12] = 1'b0; tick();
        clear_all_pend();

        // R5: pulse during service
        pend_src(12);
        enter();
        irq_line[12] = 1'b1; tick();
        irq_line[12] = 1'b0; tick();
        rd(5'd4, v); check("R5 pulse rearm", v[12], 1);
        check("R5 active not offered", irq_valid, 0);
        leave();
        vcheck("R5 offered after exit", 1, 12);
        clear_all_pend();

        // R11: line set wins over clear write
        irq_line[13] = 1'b1; tick();
        wr(5'd6, 32'(1) << 13);
        rd(5'd4, v); check("R11 set wins", v[13], 1);
        irq_line[13] = 1'b0; tick();
        clear_all_pend();
        rd(5'd4, v); check("R11 cleared later", v[13], 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule